// File: doc/BRIEF.md
# MDIO Management Transaction Engine

This block lets a host reach the management registers of an Ethernet PHY through a few byte-wide registers. The host writes a 5-bit PHY register number. For a write it also loads a 16-bit data word, low byte and high byte. It then sets a read or a write bit in the command register. The engine clocks a complete management frame out on MDC/MDIO. During a read it releases the MDIO line for the turnaround and the data phase. When the last bit has gone, it clears the command bit. The host only has to poll that bit to know the frame is over. After a read, the data register holds the 16-bit word that the PHY returned.

The PHY address placed in every frame is a parameter, fixed at 1 by default. MDC is the system clock divided by a parameter: a half period of `MDC_HALF` system clocks. A status register carries an idle flag. An autopoll enable bit can be stored and read back, but it starts nothing.

Top module: `mii_mgmt_engine`

## Requirements
- R1: After reset the command register reads 0x00, the data register reads 0x0000, the status register reads 0x80 (idle), MDC is low and `mdio_oe` is low.
- R2: A write frame is sent MSB first, one bit per MDC period. Its 64 bits are: 32 ones, start 01, opcode 01, the PHY address (default 1), the 5-bit register number, turnaround 10, then the 16-bit data word. `mdio_oe` is high for all 64 bits. A write leaves the data register unchanged.
- R3: A read frame uses opcode 10. `mdio_oe` is high for the first 46 bits and low for the two turnaround bits and the 16 data bits.
- R4: In a read, MDIO is sampled at each MDC rising edge of the 16 data bits, MSB first. After the read bit clears, the data register (low byte at 0x72, high byte at 0x73) holds the sampled word.
- R5: Writing command byte 0x20 starts a write and writing 0x40 starts a read (command register at 0x70). The started bit reads back as set while the frame runs. It clears by itself after the frame's last MDC period. Status bit 7 at 0x6D reads 0 while a frame runs and 1 otherwise.
- R6: A command byte that has both 0x40 and 0x20 set starts a read, and the command register then shows only 0x40.
- R7: A write to the command register while a frame runs is ignored completely. The running frame, the command bits and the stored autopoll bit all stay as they were.
- R8: MDC has a period of 2 × `MDC_HALF` system clocks while a frame runs, and stays low while the engine is idle.
- R9: Command bit 0x80 is stored and read back. Writing 0x80 alone starts no frame, produces no MDC edge and leaves the engine idle.
- R10: The register number at 0x71 keeps only its low 5 bits and reads back with bits 7:5 as 0. The data bytes at 0x72 and 0x73 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_o`; low means released |
| mdio_i | input | 1 | Management data from the PHY |

## Verification
Some properties are checked on every cycle. The running read or write bit must match the sequencer's busy state. The two command bits are never set together. MDC stays low while the engine is idle. MDIO holds steady through each MDC high phase. The frame type does not change while a frame runs. Other properties can only be shown by the bench scenarios, which model the PHY: the exact 64-bit frame contents and the output-enable pattern, the word captured from the PHY, the MDC period, the both-bits-set case, a command byte ignored during a busy frame, and an autopoll-only write that starts nothing.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    localparam int FRAME_LEN  = 64;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;
    localparam int WORD_W     = 16;
    localparam int REG_W      = 5;

    localparam logic [7:0] A_STATUS  = 8'h6D;
    localparam logic [7:0] A_CMD     = 8'h70;
    localparam logic [7:0] A_REGSEL  = 8'h71;
    localparam logic [7:0] A_DATA_LO = 8'h72;
    localparam logic [7:0] A_DATA_HI = 8'h73;

    localparam int CMD_WR_BIT   = 5;
    localparam int CMD_RD_BIT   = 6;
    localparam int CMD_POLL_BIT = 7;
    localparam int STAT_IDLE    = 7;

    typedef struct packed {
        logic                 busy;
        logic                 is_read;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] sh;
        logic [WORD_W-1:0]    rx;
    } seq_state_t;

    typedef struct packed {
        logic              poll;
        logic              rd;
        logic              wr;
        logic [REG_W-1:0]  regsel;
        logic [WORD_W-1:0] data;
    } host_regs_t;

endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
    parameter int MDC_HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CNT_W = (MDC_HALF < 2) ? 1 : $clog2(MDC_HALF);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MDC_HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             clk_lvl;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       tick;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == LAST);
        if (!run) begin
            st_d.cnt     = '0;
            st_d.clk_lvl = 1'b0;
        end else if (tick) begin
            st_d.cnt     = '0;
            st_d.clk_lvl = ~st_q.clk_lvl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc  = st_q.clk_lvl;
    assign rise = tick && !st_q.clk_lvl;
    assign fall = tick &&  st_q.clk_lvl;

endmodule

// File: rtl/mii_frame_seq.sv
module mii_frame_seq
    import mii_mgmt_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_read,
    input  logic [REG_W-1:0]  regsel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              is_read,
    output logic [WORD_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.is_read = start_read;
                st_d.idx     = '0;
                st_d.rx      = '0;
                if (start_read)
                    st_d.sh = {32'hFFFF_FFFF, 2'b01, 2'b10, PHY_ADDR, regsel,
                               2'b11, 16'hFFFF};
                else
                    st_d.sh = {32'hFFFF_FFFF, 2'b01, 2'b01, PHY_ADDR, regsel,
                               2'b10, wdata};
            end
        end else begin
            if (rise && st_q.is_read && (st_q.idx >= IDX_W'(DATA_FIRST)))
                st_d.rx = {st_q.rx[WORD_W-2:0], mdio_i};
            if (fall) begin
                if (st_q.idx == LAST_IDX) begin
                    st_d.busy = 1'b0;
                    done      = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.sh  = {st_q.sh[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign is_read = st_q.is_read;
    assign rdata   = st_q.rx;
    assign mdio_o  = st_q.busy ? st_q.sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = st_q.busy && !(st_q.is_read && (st_q.idx >= IDX_W'(TA_FIRST)));

    // R2: the line the PHY samples must not move during the MDC high phase
    assert_mdio_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    // R7: the frame type cannot change under a running frame
    assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> $stable(st_q.is_read));

endmodule

// File: rtl/mii_mgmt_engine.sv
module mii_mgmt_engine
    import mii_mgmt_pkg::*;
#(
    parameter int         MDC_HALF = 20,
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       mdc,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic       mdio_i
);
    host_regs_t        regs_d, regs_q;
    logic              start, start_read;
    logic              seq_busy, seq_done, seq_is_read;
    logic              tick_rise, tick_fall;
    logic [WORD_W-1:0] seq_rdata;

    always_comb begin
        regs_d     = regs_q;
        start      = 1'b0;
        start_read = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                A_CMD: if (!seq_busy) begin
                    regs_d.poll = bus_wdata[CMD_POLL_BIT];
                    if (bus_wdata[CMD_RD_BIT]) begin
                        regs_d.rd  = 1'b1;
                        start      = 1'b1;
                        start_read = 1'b1;
                    end else if (bus_wdata[CMD_WR_BIT]) begin
                        regs_d.wr = 1'b1;
                        start     = 1'b1;
                    end
                end
                A_REGSEL:  regs_d.regsel     = bus_wdata[REG_W-1:0];
                A_DATA_LO: regs_d.data[7:0]  = bus_wdata;
                A_DATA_HI: regs_d.data[15:8] = bus_wdata;
                default: ;
            endcase
        end
        if (seq_done) begin
            regs_d.rd = 1'b0;
            regs_d.wr = 1'b0;
            if (seq_is_read) regs_d.data = seq_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CMD: begin
                bus_rdata[CMD_POLL_BIT] = regs_q.poll;
                bus_rdata[CMD_RD_BIT]   = regs_q.rd;
                bus_rdata[CMD_WR_BIT]   = regs_q.wr;
            end
            A_REGSEL:  bus_rdata[REG_W-1:0] = regs_q.regsel;
            A_DATA_LO: bus_rdata = regs_q.data[7:0];
            A_DATA_HI: bus_rdata = regs_q.data[15:8];
            A_STATUS:  bus_rdata[STAT_IDLE] = !seq_busy;
            default: ;
        endcase
    end

    mii_mdc_gen #(.MDC_HALF(MDC_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_busy),
        .mdc   (mdc),
        .rise  (tick_rise),
        .fall  (tick_fall)
    );

    mii_frame_seq #(.PHY_ADDR(PHY_ADDR)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_read (start_read),
        .regsel     (regs_q.regsel),
        .wdata      (regs_q.data),
        .rise       (tick_rise),
        .fall       (tick_fall),
        .mdc        (mdc),
        .mdio_i     (mdio_i),
        .busy       (seq_busy),
        .done       (seq_done),
        .is_read    (seq_is_read),
        .rdata      (seq_rdata),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    // R5: a set command bit and a running frame always go together
    assert_cmd_tracks_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.rd || regs_q.wr) == seq_busy);

    // R6: never both kinds of command at once
    assert_cmd_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({regs_q.rd, regs_q.wr}));

    // R8: no clock activity toward the PHY while idle
    assert_mdc_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> !mdc);

endmodule

// File: tb/tb_mii_mgmt_engine.sv
module tb_mii_mgmt_engine;
    localparam int PERIOD = 10;
    localparam int HALF   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       mdc, mdio_o, mdio_oe, mdio_i;

    int n_vec = 0;
    int n_bad = 0;

    mii_mgmt_engine #(.MDC_HALF(HALF), .PHY_ADDR(5'd1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(PERIOD/2) clk = ~clk;

    // PHY model: records every bit seen at an MDC rise, answers reads
    int          edge_cnt = 0;
    logic [63:0] frame_bits = '0;
    logic [63:0] oe_bits = '0;
    logic [15:0] phy_word = '0;
    time         t_first = 0, t_second = 0;

    always @(posedge mdc) begin
        if (edge_cnt < 64) begin
            frame_bits[63-edge_cnt] = mdio_o;
            oe_bits[63-edge_cnt]    = mdio_oe;
        end
        if (edge_cnt == 0) t_first = $time;
        if (edge_cnt == 1) t_second = $time;
        edge_cnt = edge_cnt + 1;
    end

    assign mdio_i = (edge_cnt >= 48 && edge_cnt < 64) ? phy_word[63-edge_cnt] : 1'b1;

    function automatic logic [63:0] exp_frame(bit rd, logic [4:0] ra, logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), 5'd1, ra,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wd)};
    endfunction

    function automatic logic [63:0] exp_oe(bit rd);
        return rd ? ~64'h3FFFF : ~64'h0;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(output bit ok);
        logic [7:0] c;
        ok = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            bus_read(8'h70, c);
            if (c[6:5] == 2'b00) begin ok = 1'b1; break; end
        end
    endtask

    // one complete transaction with the full set of checks
    task automatic run_txn(logic [7:0] cmd, logic [4:0] ra, logic [15:0] wd,
                           logic [15:0] pw, bit poke_busy);
        logic [7:0]  v, lo, hi;
        bit          rd, ok;
        logic [63:0] m;
        rd = cmd[6];
        phy_word = pw;
        bus_write(8'h71, {3'b101, ra});
        bus_write(8'h72, wd[7:0]);
        bus_write(8'h73, wd[15:8]);
        edge_cnt = 0;
        bus_write(8'h70, cmd);
        bus_read(8'h70, v);
        check(v[6:5] == (rd ? 2'b10 : 2'b01), rd ? "R6" : "R5", "command bit while running",
              v, rd ? 8'h40 : 8'h20);
        bus_read(8'h6D, v);
        check(v == 8'h00, "R5", "status while running", v, 8'h00);
        if (poke_busy) begin
            bus_write(8'h70, 8'hA0);
            bus_read(8'h70, v);
            check(v == {cmd[7], rd, !rd, 5'b0}, "R7", "command byte after busy write", v,
                  {cmd[7], rd, !rd, 5'b0});
        end
        wait_idle(ok);
        check(ok, "R5", "command bit clears", {63'b0, ok}, 64'd1);
        bus_read(8'h6D, v);
        check(v == 8'h80, "R5", "status idle after frame", v, 8'h80);
        check(edge_cnt == 64, "R2", "MDC rises per frame", edge_cnt, 64);
        m = exp_frame(rd, ra, wd);
        check((frame_bits & exp_oe(rd)) == (m & exp_oe(rd)), rd ? "R3" : "R2",
              "frame bits", frame_bits & exp_oe(rd), m & exp_oe(rd));
        check(oe_bits == exp_oe(rd), "R3", "output enable pattern", oe_bits, exp_oe(rd));
        check((t_second - t_first) == 2*HALF*PERIOD, "R8", "MDC period",
              t_second - t_first, 2*HALF*PERIOD);
        check(mdc == 1'b0, "R8", "MDC low when idle", mdc, 0);
        bus_read(8'h72, lo);
        bus_read(8'h73, hi);
        check({hi, lo} == (rd ? pw : wd), rd ? "R4" : "R2", "data register after frame",
              {hi, lo}, rd ? pw : wd);
    endtask

    initial begin
        #(PERIOD*200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int         e0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h70, v); check(v == 8'h00, "R1", "command at reset", v, 8'h00);
        bus_read(8'h6D, v); check(v == 8'h80, "R1", "status at reset", v, 8'h80);
        bus_read(8'h72, v); check(v == 8'h00, "R1", "data lo at reset", v, 8'h00);
        bus_read(8'h73, v); check(v == 8'h00, "R1", "data hi at reset", v, 8'h00);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins at reset", {mdc, mdio_oe}, 0);

        // R10 register readback
        bus_write(8'h71, 8'hEB);
        bus_read(8'h71, v); check(v == 8'h0B, "R10", "register number readback", v, 8'h0B);
        bus_write(8'h72, 8'h5A); bus_write(8'h73, 8'hC3);
        bus_read(8'h72, v); check(v == 8'h5A, "R10", "data lo readback", v, 8'h5A);
        bus_read(8'h73, v); check(v == 8'hC3, "R10", "data hi readback", v, 8'hC3);

        // R9 autopoll only: stored, no frame
        e0 = edge_cnt;
        bus_write(8'h70, 8'h80);
        bus_read(8'h70, v); check(v == 8'h80, "R9", "autopoll bit readback", v, 8'h80);
        repeat (4*HALF) @(negedge clk);
        bus_read(8'h6D, v); check(v == 8'h80, "R9", "still idle after autopoll", v, 8'h80);
        check(edge_cnt == e0, "R9", "no MDC edge from autopoll", edge_cnt, e0);
        bus_write(8'h70, 8'h00);

        // directed corners
        run_txn(8'h20, 5'd0,  16'hFFFF, 16'h0000, 1'b0);  // R2 write all ones
        run_txn(8'h40, 5'd31, 16'h1234, 16'h0000, 1'b0);  // R3 read zeros
        run_txn(8'h40, 5'd2,  16'h0000, 16'hA5C3, 1'b0);  // R4 read pattern
        run_txn(8'h60, 5'd9,  16'h0F0F, 16'h8001, 1'b0);  // R6 both bits
        run_txn(8'h40, 5'd17, 16'h0000, 16'h7E81, 1'b1);  // R7 poke while busy
        run_txn(8'hA0, 5'd4,  16'hBEEF, 16'h0000, 1'b1);  // R7 write with poll kept
        bus_read(8'h70, v); check(v == 8'h80, "R7", "autopoll kept after ignored write", v, 8'h80);

        // random mix
        for (int k = 0; k < 10; k++) begin
            logic [7:0] c;
            c = ($urandom % 2) ? 8'h40 : 8'h20;
            run_txn(c, 5'($urandom), 16'($urandom), 16'($urandom), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule